// File: doc/BRIEF.md
# Passive Smart-Card Character Sniffer

This block listens to the half-duplex I/O line of a smart-card interface without ever driving it. It brings the card reset, card clock and I/O lines into the system clock domain, notices the falling edge that opens each character, and from then on measures time only in rising edges of the card clock. The system-clock period therefore has no effect on where bits are sampled, and neither does the phase between card clock and I/O edges.

For every character it delivers the eight data bits, the parity bit, the I/O level seen in the middle of the start bit and a flag saying whether the receiving side signalled an error during the guard time. All four arrive together with a one-cycle valid strobe. The bits are passed on exactly as they appeared on the wire: convention decoding, parity checking and deciding who sent the character are left to whatever consumes the output.

The bit rate is set by a half-etu count held in a register that comes out of reset at 186 card clocks (an etu of 372). A later block can load a new count once the bit rate has been renegotiated. The receiver takes a copy of the count when each character starts, so a load only applies from the next character onward.

Top module: `cardline_sniffer`

## Requirements
- R1: Each of the three card lines passes through a two-flop synchroniser. Reception begins only on a high-to-low change of the synchronised I/O line. After system reset and while the line stays idle, every output is 0.
- R2: With H the half-etu count latched at the start edge, data bit n (n = 0..7) is sampled at rising card-clock edge (2n+3)·H after the start edge and the parity bit at edge 19·H. Only card-clock edges are counted, so the same waveform decodes the same way at any card-clock period.
- R3: The I/O level at card-clock edge H (mid start bit) is reported on `char_start_lvl`.
- R4: The data bit sampled first lands in `char_data[0]` and the last in `char_data[7]`. The parity bit goes to `char_parity`. Nothing is inverted.
- R5: `char_err` is 1 when I/O is low at card-clock edge 22·H (11 etu) and 0 when it is high.
- R6: `char_valid` pulses for exactly one system cycle after card-clock edge 24·H. The four result outputs change only together with that pulse and hold their value until the next one.
- R7: If I/O is still low at edge 24·H, the receiver does not look for a new start until I/O has gone high again. One character yields exactly one strobe.
- R8: While the synchronised card reset is low, the receiver is held idle and any partly received character is dropped without a strobe. Reception resumes normally once card reset goes high.
- R9: The half-etu register resets to 186.
- R10: A load with a nonzero value replaces the half-etu count. It takes effect at the next start edge and does not change a character already in progress. A load of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_rst_in | input | 1 | Card reset line, asynchronous, active low |
| card_clk_in | input | 1 | Card clock line, asynchronous |
| card_io_in | input | 1 | Card I/O line, asynchronous, idles high |
| half_etu_we | input | 1 | Load strobe for the half-etu count |
| half_etu_din | input | HALF_W | New half-etu count in card clocks |
| char_valid | output | 1 | One-cycle strobe: a character is complete |
| char_data | output | 8 | Data bits as received, first bit in bit 0 |
| char_parity | output | 1 | Received parity bit |
| char_start_lvl | output | 1 | I/O level at the middle of the start bit |
| char_err | output | 1 | Error signal seen at 11 etu |

## Verification
The bench aims at each sampling point with a waveform whose transitions fall half a card clock away from the point. A counter that is off by one half-etu, or that counts system cycles instead of card clocks, then decodes wrong data or parity, and the slowed card-clock case shows this clearly. It also sends a start pulse too short to be a real start bit, an error signal held past 12 etu, a half-etu load in the middle of a character, a load of zero, and a card reset dropped in mid-character. A design that got these wrong would report a wrong start level, produce a second strobe, stretch or shrink the character in flight, stop counting altogether, or emit the remains of an aborted character.

// File: rtl/csn_pkg.sv
package csn_pkg;

    // Sample points counted in half-etu steps from the start edge.
    localparam int unsigned HIDX_W = 5;
    localparam logic [HIDX_W-1:0] PT_START  = 5'd1;
    localparam logic [HIDX_W-1:0] PT_DATA_LO = 5'd3;
    localparam logic [HIDX_W-1:0] PT_DATA_HI = 5'd17;
    localparam logic [HIDX_W-1:0] PT_PARITY = 5'd19;
    localparam logic [HIDX_W-1:0] PT_ERR    = 5'd22;
    localparam logic [HIDX_W-1:0] PT_END    = 5'd24;

    // Synchroniser lane positions.
    localparam int unsigned LANE_RST = 0;
    localparam int unsigned LANE_CLK = 1;
    localparam int unsigned LANE_IO  = 2;
    localparam int unsigned LANES    = 3;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_RUN   = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       err;
        logic       start_lvl;
        logic       parity;
        logic [7:0] data;
    } char_rec_t;

    function automatic logic is_data_pt(input logic [HIDX_W-1:0] idx);
        return (idx >= PT_DATA_LO) && (idx <= PT_DATA_HI) && idx[0];
    endfunction

    function automatic logic [2:0] data_slot(input logic [HIDX_W-1:0] idx);
        logic [HIDX_W-1:0] rel;
        rel = idx - PT_DATA_LO;
        return rel[3:1];
    endfunction

endpackage

// File: rtl/csn_sync.sv
module csn_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/csn_half_reg.sv
module csn_half_reg #(
    parameter int unsigned HALF_W   = 12,
    parameter int unsigned HALF_RST = 186
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] q
);
    localparam logic [HALF_W-1:0] RST_VAL = HALF_W'(HALF_RST);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we && (din != '0))
            q <= din;
    end
endmodule

// File: rtl/csn_rx_engine.sv
module csn_rx_engine
    import csn_pkg::*;
#(
    parameter int unsigned HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_rst_s,
    input  logic              clk_tick,
    input  logic              io_s,
    input  logic [HALF_W-1:0] half_etu,
    output char_rec_t         rec,
    output logic              rec_valid,
    output logic              busy
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    rx_state_e         state;
    logic [HALF_W-1:0] sub;
    logic [HALF_W-1:0] cur_half;
    logic [HIDX_W-1:0] hidx;
    logic [HIDX_W-1:0] hidx_nxt;
    logic              io_prev;
    logic              step;
    char_rec_t         work;

    assign hidx_nxt = hidx + 5'd1;
    assign step     = clk_tick && (sub == cur_half - ONE);
    assign busy     = (state != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            sub       <= '0;
            hidx      <= '0;
            cur_half  <= ONE;
            work      <= '0;
            rec       <= '0;
            rec_valid <= 1'b0;
            io_prev   <= 1'b1;
        end else begin
            io_prev   <= io_s;
            rec_valid <= 1'b0;
            if (!card_rst_s) begin
                state <= RX_IDLE;
            end else begin
                unique case (state)
                    RX_IDLE: begin
                        if (io_prev && !io_s) begin
                            state    <= RX_RUN;
                            sub      <= '0;
                            hidx     <= '0;
                            cur_half <= half_etu;
                            work     <= '0;
                        end
                    end
                    RX_RUN: begin
                        if (step) begin
                            sub  <= '0;
                            hidx <= hidx_nxt;
                            if (hidx_nxt == PT_START)
                                work.start_lvl <= io_s;
                            if (is_data_pt(hidx_nxt))
                                work.data[data_slot(hidx_nxt)] <= io_s;
                            if (hidx_nxt == PT_PARITY)
                                work.parity <= io_s;
                            if (hidx_nxt == PT_ERR)
                                work.err <= ~io_s;
                            if (hidx_nxt == PT_END) begin
                                rec       <= work;
                                rec_valid <= 1'b1;
                                state     <= io_s ? RX_IDLE : RX_DRAIN;
                            end
                        end else if (clk_tick) begin
                            sub <= sub + ONE;
                        end
                    end
                    RX_DRAIN: begin
                        if (io_s) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cardline_sniffer.sv
module cardline_sniffer
    import csn_pkg::*;
#(
    parameter int unsigned HALF_W   = 12,
    parameter int unsigned HALF_RST = 186,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_rst_in,
    input  logic              card_clk_in,
    input  logic              card_io_in,
    input  logic              half_etu_we,
    input  logic [HALF_W-1:0] half_etu_din,
    output logic              char_valid,
    output logic [7:0]        char_data,
    output logic              char_parity,
    output logic              char_start_lvl,
    output logic              char_err
);
    localparam logic [LANES-1:0] SYNC_RST = 3'b100;

    logic [LANES-1:0]  lanes_raw;
    logic [LANES-1:0]  lanes_s;
    logic              card_rst_s;
    logic              clk_s;
    logic              io_s;
    logic              clk_prev;
    logic              clk_tick;
    logic [HALF_W-1:0] half_cur;
    logic              rx_busy;
    char_rec_t         rec;

    assign lanes_raw[LANE_RST] = card_rst_in;
    assign lanes_raw[LANE_CLK] = card_clk_in;
    assign lanes_raw[LANE_IO]  = card_io_in;

    csn_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lanes_raw),
        .q   (lanes_s)
    );

    assign card_rst_s = lanes_s[LANE_RST];
    assign clk_s      = lanes_s[LANE_CLK];
    assign io_s       = lanes_s[LANE_IO];

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= clk_s;
    end
    assign clk_tick = clk_s && !clk_prev;

    csn_half_reg #(.HALF_W(HALF_W), .HALF_RST(HALF_RST)) u_half (
        .clk (clk),
        .rst (rst),
        .we  (half_etu_we),
        .din (half_etu_din),
        .q   (half_cur)
    );

    csn_rx_engine #(.HALF_W(HALF_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .card_rst_s (card_rst_s),
        .clk_tick   (clk_tick),
        .io_s       (io_s),
        .half_etu   (half_cur),
        .rec        (rec),
        .rec_valid  (char_valid),
        .busy       (rx_busy)
    );

    assign char_data      = rec.data;
    assign char_parity    = rec.parity;
    assign char_start_lvl = rec.start_lvl;
    assign char_err       = rec.err;
endmodule

// File: rtl/csn_checker.sv
module csn_checker #(
    parameter int unsigned HALF_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              card_rst_s,
    input logic              io_s,
    input logic              busy,
    input logic              char_valid,
    input logic [10:0]       char_bits,
    input logic              half_we,
    input logic [HALF_W-1:0] half_din,
    input logic [HALF_W-1:0] half_q
);
    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(io_s, 2) && !$past(io_s))); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid); // R6

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !char_valid |-> $stable(char_bits)); // R6

    AST_QUIET_IN_CARD_RST: assert property (@(posedge clk) disable iff (rst)
        $past(!card_rst_s) |-> !char_valid); // R8

    AST_ZERO_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (half_we && (half_din == '0)) |=> $stable(half_q)); // R10
endmodule

bind cardline_sniffer csn_checker #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .card_rst_s (card_rst_s),
    .io_s       (io_s),
    .busy       (rx_busy),
    .char_valid (char_valid),
    .char_bits  ({char_err, char_start_lvl, char_parity, char_data}),
    .half_we    (half_etu_we),
    .half_din   (half_etu_din),
    .half_q     (half_cur)
);

// File: tb/cardline_sniffer_bench.sv
module cardline_sniffer_bench;
    import csn_pkg::*;

    localparam int HW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          card_rst_in = 1'b0;
    logic          card_clk_in = 1'b0;
    logic          card_io_in = 1'b1;
    logic          half_etu_we = 1'b0;
    logic [HW-1:0] half_etu_din = '0;
    logic          char_valid;
    logic [7:0]    char_data;
    logic          char_parity;
    logic          char_start_lvl;
    logic          char_err;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    int cclk_half = 2;
    bit prev_v = 1'b0;
    char_rec_t expq[$];
    char_rec_t last_exp = '0;
    char_rec_t got;

    always #2 clk = ~clk;

    initial forever begin
        repeat (cclk_half) @(posedge clk);
        card_clk_in <= ~card_clk_in;
    end

    cardline_sniffer #(.HALF_W(HW)) u_cardline_sniffer (
        .clk            (clk),
        .rst            (rst),
        .card_rst_in    (card_rst_in),
        .card_clk_in    (card_clk_in),
        .card_io_in     (card_io_in),
        .half_etu_we    (half_etu_we),
        .half_etu_din   (half_etu_din),
        .char_valid     (char_valid),
        .char_data      (char_data),
        .char_parity    (char_parity),
        .char_start_lvl (char_start_lvl),
        .char_err       (char_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_v && char_valid)
                check(1'b0, "R6", "strobe longer than one cycle", 2, 1);
            prev_v = char_valid;
            if (char_valid) begin
                valid_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, "R8", "unexpected strobe", 1, 0);
                end else begin
                    got = expq.pop_front();
                    check(char_data == got.data, "R4", "data",
                          int'(char_data), int'(got.data));
                    check(char_parity == got.parity, "R4", "parity",
                          int'(char_parity), int'(got.parity));
                    check(char_start_lvl == got.start_lvl, "R3", "start level",
                          int'(char_start_lvl), int'(got.start_lvl));
                    check(char_err == got.err, "R5", "error flag",
                          int'(char_err), int'(got.err));
                end
            end
        end
    end

    task automatic wait_cticks(input int n);
        repeat (n) @(negedge card_clk_in);
    endtask

    task automatic load_half(input int v);
        @(posedge clk);
        half_etu_we  <= 1'b1;
        half_etu_din <= HW'(v);
        @(posedge clk);
        half_etu_we  <= 1'b0;
    endtask

    // Driver: pushes the expected record and drives one character.
    task automatic send_char(input logic [7:0] d, input logic p, input bit err_sig,
                             input bit glitch, input int h, input bit expect_it);
        char_rec_t e;
        e.data = d; e.parity = p; e.err = err_sig; e.start_lvl = glitch;
        if (expect_it) begin
            expq.push_back(e);
            last_exp = e;
        end
        wait_cticks(1);
        card_io_in = 1'b0;
        if (glitch) begin
            wait_cticks(1);
            card_io_in = 1'b1;
            wait_cticks(2*h - 1);
        end else begin
            wait_cticks(2*h);
        end
        for (int i = 0; i < 8; i++) begin
            card_io_in = d[i];
            wait_cticks(2*h);
        end
        card_io_in = p;
        wait_cticks(2*h);
        card_io_in = 1'b1;
        if (err_sig) begin
            wait_cticks(h);
            card_io_in = 1'b0;
            wait_cticks(4*h);
            card_io_in = 1'b1;
            wait_cticks(2*h);
        end else begin
            wait_cticks(6*h);
        end
        repeat (8) @(posedge clk);
    endtask

    initial begin
        int n;
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not complete", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(posedge clk);
        rst <= 1'b0;
        card_rst_in <= 1'b1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        // R1: reset state and idle line
        check(char_valid == 1'b0, "R1", "valid after reset", int'(char_valid), 0);
        check({char_err, char_start_lvl, char_parity, char_data} == 11'd0, "R1",
              "fields after reset",
              int'({char_err, char_start_lvl, char_parity, char_data}), 0);
        repeat (200) @(posedge clk);
        check(valid_seen == 0, "R1", "strobes on idle line", valid_seen, 0);

        // R9: default half-etu of 186
        send_char(8'hA5, 1'b1, 1'b0, 1'b0, 186, 1'b1);

        // R2/R4: several patterns at half-etu 4
        load_half(4);
        send_char(8'h3C, 1'b0, 1'b0, 1'b0, 4, 1'b1);
        send_char(8'h00, 1'b0, 1'b0, 1'b0, 4, 1'b1);
        send_char(8'hFF, 1'b1, 1'b0, 1'b0, 4, 1'b1);
        send_char(8'h81, 1'b1, 1'b0, 1'b0, 4, 1'b1);

        // R3: start pulse too short
        send_char(8'h5A, 1'b1, 1'b0, 1'b1, 4, 1'b1);

        // R5/R7: error signal held past 12 etu
        n = valid_seen;
        send_char(8'hC3, 1'b0, 1'b1, 1'b0, 4, 1'b1);
        repeat (40) @(posedge clk);
        check(valid_seen == n + 1, "R7", "strobes for held-low error", valid_seen - n, 1);

        // R2: slower card clock, same waveform in card clocks
        cclk_half = 3;
        repeat (20) @(posedge clk);
        send_char(8'h96, 1'b0, 1'b0, 1'b0, 4, 1'b1);
        cclk_half = 2;
        repeat (20) @(posedge clk);

        // R10: load in mid-character, then next character at new rate
        fork
            send_char(8'h69, 1'b1, 1'b0, 1'b0, 4, 1'b1);
            begin wait_cticks(40); load_half(6); end
        join
        send_char(8'h17, 1'b0, 1'b0, 1'b0, 6, 1'b1);
        // R10: zero load ignored
        load_half(0);
        send_char(8'hE4, 1'b1, 1'b0, 1'b0, 6, 1'b1);

        // R8: card reset dropped mid-character
        n = valid_seen;
        fork
            send_char(8'h55, 1'b1, 1'b0, 1'b0, 6, 1'b0);
            begin wait_cticks(48); card_rst_in = 1'b0; end
        join
        repeat (20) @(posedge clk);
        check(valid_seen == n, "R8", "strobe during card reset", valid_seen - n, 0);
        card_rst_in = 1'b1;
        repeat (50) @(posedge clk);
        send_char(8'h2B, 1'b0, 1'b0, 1'b0, 6, 1'b1);

        repeat (100) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R2", "characters not delivered", expq.size(), 0);
        check(char_data == last_exp.data && char_parity == last_exp.parity, "R6",
              "held data after strobe", int'(char_data), int'(last_exp.data));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule